// File: doc/BRIEF.md
# Single-Cycle Reduced RISC Core

This block is a 32-bit processor core that runs a nine-instruction subset of a classic RISC instruction set. The subset covers register-register arithmetic and logic, word loads and stores, one conditional branch and one unconditional jump. Each instruction completes in one clock cycle.

In every cycle the core presents the program counter on the instruction address port and decodes the word that comes back. It then reads two source registers and forms a result or an address in the ALU. A store drives the data port, and at the rising edge the core writes the result or the loaded word back to the register file. The program counter then moves to the next address.

Both memory ports are plain combinational buses with no valid/ready handshake. A single-cycle core must receive the instruction word and the load data within the same cycle, so it cannot accept back-pressure. The attached memories must answer within the cycle.

Top module: `mcore_top`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and all 32 registers become 0. During reset `imem_addr` reads 0.
- R2: Instructions use these fields: opcode at bits 31:26, source register A at 25:21, source register B at 20:16, destination at 15:11, function code at 5:0. With opcode 0x00, function 0x20 writes A+B and function 0x22 writes A-B to the destination register, both wrapping modulo 2^32.
- R3: With opcode 0x00, function 0x24 writes A AND B and function 0x25 writes A OR B to the destination register.
- R4: With opcode 0x00, function 0x2A writes 1 when A is less than B as signed two's-complement values, and 0 otherwise.
- R5: Opcode 0x23 (load) reads the data word at address A plus the sign-extended 16-bit immediate (bits 15:0). It writes that word to the register named in bits 20:16.
- R6: Opcode 0x2B (store) raises `dmem_we` for that cycle only. It drives `dmem_addr` with A plus the sign-extended immediate and `dmem_wdata` with register B, and it writes no register.
- R7: Opcode 0x04 compares A and B. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise the next PC is PC+4.
- R8: Opcode 0x02 sets the next PC to bits 31:28 of PC+4, followed by the 26-bit index from bits 25:0, followed by two zero bits.
- R9: Register 0 always reads as zero, and any write to it has no effect.
- R10: Any other opcode, or opcode 0x00 with an unlisted function code, writes no register and no memory. The next PC is PC+4.
- R11: Every instruction other than a taken branch or a jump advances the PC by 4, and the PC stays word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe; the memory writes at the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, valid in the same cycle |

## Verification
The embedded assertions assume that `imem_data` carries a known word in every cycle after reset is released, and that it changes only in response to `imem_addr`. The PC and jump checks rely on this. The bench meets the assumption by filling its instruction array completely before it releases reset; every unused slot holds a branch-to-self. It also indexes both arrays with address bits 7:2, so every address the core can produce maps to an initialised word.

// File: rtl/mcore_pkg.sv
package mcore_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned REG_N  = 32;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_JUMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_is_rd;
    logic    src_is_imm;
    logic    mem_we;
    logic    load_sel;
    logic    is_branch;
    logic    is_jump;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/mcore_decode.sv
module mcore_decode
  import mcore_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    case (opcode)
      OPC_RTYPE: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.reg_we    = 1'b1;
        case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OPC_LOAD: begin
        ctrl.reg_we     = 1'b1;
        ctrl.src_is_imm = 1'b1;
        ctrl.load_sel   = 1'b1;
      end
      OPC_STORE: begin
        ctrl.src_is_imm = 1'b1;
        ctrl.mem_we     = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_op    = ALU_SUB;
      end
      OPC_JUMP: ctrl.is_jump = 1'b1;
      default: ctrl.reg_we = 1'b0;
    endcase
  end

endmodule

// File: rtl/mcore_regfile.sv
module mcore_regfile #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(DEPTH)-1:0] ra1,
  input  logic [$clog2(DEPTH)-1:0] ra2,
  output logic [DATA_W-1:0]        rd1,
  output logic [DATA_W-1:0]        rd2,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] wa,
  input  logic [DATA_W-1:0]        wd
);

  localparam int unsigned AW = $clog2(DEPTH);

  logic [DATA_W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (we && (wa != AW'(0))) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];

  // R9: entry zero is never disturbed by a write
  assert_zero_reg_a_R9: assert property (@(posedge clk) disable iff (rst)
    (ra1 == AW'(0)) |-> (rd1 == '0));
  assert_zero_reg_b_R9: assert property (@(posedge clk) disable iff (rst)
    (ra2 == AW'(0)) |-> (rd2 == '0));

endmodule

// File: rtl/mcore_alu.sv
module mcore_alu
  import mcore_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         eq
);

  logic lt;
  assign lt = $signed(a) < $signed(b);

  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, lt};
      default: y = a + b;
    endcase
  end

  assign eq = (a == b);

endmodule

// File: rtl/mcore_top.sv
module mcore_top
  import mcore_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);

  localparam int unsigned RAW = $clog2(REG_N);

  logic [WORD_W-1:0] pc, pc_plus4, pc_next, br_target, j_target;
  logic [WORD_W-1:0] imm_ext, rd1, rd2, alu_b, alu_y, wb_data;
  logic [RAW-1:0]    f_rs, f_rt, f_rd, wa;
  logic [5:0]        f_op, f_fn;
  logic              eq, take_branch;
  ctrl_t             ctrl;

  assign f_op    = imem_data[31:26];
  assign f_rs    = imem_data[25:21];
  assign f_rt    = imem_data[20:16];
  assign f_rd    = imem_data[15:11];
  assign f_fn    = imem_data[5:0];
  assign imm_ext = {{(WORD_W-16){imem_data[15]}}, imem_data[15:0]};

  mcore_decode dec_i (
    .opcode (f_op),
    .funct  (f_fn),
    .ctrl   (ctrl)
  );

  mcore_regfile #(.DATA_W(WORD_W), .DEPTH(REG_N)) rf_i (
    .clk (clk),
    .rst (rst),
    .ra1 (f_rs),
    .ra2 (f_rt),
    .rd1 (rd1),
    .rd2 (rd2),
    .we  (ctrl.reg_we),
    .wa  (wa),
    .wd  (wb_data)
  );

  assign alu_b = ctrl.src_is_imm ? imm_ext : rd2;

  mcore_alu #(.W(WORD_W)) alu_i (
    .a  (rd1),
    .b  (alu_b),
    .op (ctrl.alu_op),
    .y  (alu_y),
    .eq (eq)
  );

  assign wa      = ctrl.dst_is_rd ? f_rd : f_rt;
  assign wb_data = ctrl.load_sel ? dmem_rdata : alu_y;

  assign pc_plus4    = pc + 32'd4;
  assign br_target   = pc_plus4 + {imm_ext[WORD_W-3:0], 2'b00};
  assign j_target    = {pc_plus4[31:28], imem_data[25:0], 2'b00};
  assign take_branch = ctrl.is_branch && eq;

  always_comb begin
    if (ctrl.is_jump)  pc_next = j_target;
    else if (take_branch) pc_next = br_target;
    else pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rd2;
  assign dmem_we    = ctrl.mem_we;

  assert_pc_aligned_R11: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);
  assert_pc_seq_R11: assert property (@(posedge clk) disable iff (rst)
    (f_op != OPC_JUMP && !(f_op == OPC_BEQ && rd1 == rd2)) |=> (pc == $past(pc) + 32'd4));
  assert_jump_target_R8: assert property (@(posedge clk) disable iff (rst)
    (f_op == OPC_JUMP) |=> (pc[27:2] == $past(imem_data[25:0])));
  assert_store_only_R6: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (f_op == OPC_STORE));
  assert_slt_bool_R4: assert property (@(posedge clk) disable iff (rst)
    (f_op == OPC_RTYPE && f_fn == FN_SLT) |-> (wb_data[31:1] == '0));

endmodule

// File: tb/mcore_top_tb_top.sv
`timescale 1ns/1ps
module mcore_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  localparam logic [31:0] HALT = {6'h04, 5'd0, 5'd0, 16'hFFFF};

  always #10 clk = ~clk;

  mcore_top dut_i (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] enc_j(int idx);
    return {6'h02, idx[25:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic prep();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 64; i++) begin
      imem[i] = HALT;
      dmem[i] = '0;
    end
  endtask

  task automatic start();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic t_alu();
    prep();
    dmem[0] = 32'd7; dmem[1] = 32'hFFFF_FFFD; dmem[2] = 32'h7FFF_FFFF; dmem[11] = 32'h55;
    imem[0]  = enc_i(6'h23, 0, 1, 0);
    imem[1]  = enc_i(6'h23, 0, 2, 4);
    imem[2]  = enc_i(6'h23, 0, 3, 8);
    imem[3]  = enc_r(1, 2, 4, 6'h20);
    imem[4]  = enc_r(2, 1, 5, 6'h22);
    imem[5]  = enc_r(1, 2, 6, 6'h24);
    imem[6]  = enc_r(1, 2, 7, 6'h25);
    imem[7]  = enc_r(2, 1, 8, 6'h2A);
    imem[8]  = enc_r(1, 2, 9, 6'h2A);
    imem[9]  = enc_r(3, 1, 10, 6'h20);
    for (int k = 0; k < 7; k++) imem[10+k] = enc_i(6'h2B, 0, 4+k, 16+4*k);
    imem[17] = enc_r(3, 2, 11, 6'h2A);
    imem[18] = enc_i(6'h2B, 0, 11, 44);
    start();
    step(25);
    chk("R2 add", dmem[4], 32'd4);
    chk("R2 sub", dmem[5], 32'hFFFF_FFF6);
    chk("R3 and", dmem[6], 32'd5);
    chk("R3 or", dmem[7], 32'hFFFF_FFFF);
    chk("R4 slt neg<pos", dmem[8], 32'd1);
    chk("R4 slt pos<neg", dmem[9], 32'd0);
    chk("R2 add wrap", dmem[10], 32'h8000_0006);
    chk("R4 slt signed not unsigned", dmem[11], 32'd0);
  endtask

  task automatic t_reset();
    prep();
    dmem[0] = 32'hDEAD_BEEF; dmem[1] = 32'hDEAD_BEEF;
    imem[0] = enc_i(6'h2B, 0, 5, 0);
    imem[1] = enc_i(6'h2B, 0, 10, 4);
    @(negedge clk); #1;
    chk("R1 pc in reset", imem_addr, 32'd0);
    start();
    chk("R1 pc after reset", imem_addr, 32'd0);
    step(4);
    chk("R1 reg r5 cleared", dmem[0], 32'd0);
    chk("R1 reg r10 cleared", dmem[1], 32'd0);
  endtask

  task automatic t_mem();
    prep();
    dmem[3] = 32'd32; dmem[7] = 32'h1234_5678;
    imem[0] = enc_i(6'h23, 0, 12, 12);
    imem[1] = enc_i(6'h23, 12, 11, -4);
    imem[2] = enc_i(6'h2B, 12, 11, 8);
    imem[3] = enc_i(6'h2B, 12, 11, -32);
    imem[4] = enc_i(6'h2B, 12, 11, 0);
    start();
    chk("R6 no strobe on load", {31'd0, dmem_we}, 32'd0);
    step(1);
    chk("R5 load addr neg offset", dmem_addr, 32'd28);
    step(1);
    chk("R6 strobe on store", {31'd0, dmem_we}, 32'd1);
    chk("R6 store addr", dmem_addr, 32'd40);
    chk("R6 store data", dmem_wdata, 32'h1234_5678);
    step(5);
    chk("R5 loaded word stored", dmem[10], 32'h1234_5678);
    chk("R6 store neg offset", dmem[0], 32'h1234_5678);
    chk("R6 store writes no reg", dmem[8], 32'h1234_5678);
  endtask

  task automatic t_branch();
    prep();
    dmem[0] = 32'd5; dmem[1] = 32'd6;
    imem[0] = enc_i(6'h23, 0, 1, 0);
    imem[1] = enc_i(6'h23, 0, 2, 4);
    imem[2] = enc_i(6'h04, 1, 2, 2);
    imem[3] = enc_i(6'h2B, 0, 1, 8);
    imem[4] = enc_i(6'h04, 1, 1, 2);
    imem[5] = enc_i(6'h2B, 0, 1, 12);
    imem[6] = enc_i(6'h2B, 0, 1, 16);
    imem[7] = enc_i(6'h2B, 0, 2, 20);
    start();
    step(3);
    chk("R7 not taken pc", imem_addr, 32'd12);
    step(2);
    chk("R7 taken pc", imem_addr, 32'd28);
    step(4);
    chk("R7 backward self branch", imem_addr, 32'd32);
    chk("R7 fallthrough store", dmem[2], 32'd5);
    chk("R7 skipped store", dmem[3], 32'd0);
    chk("R7 target store", dmem[5], 32'd6);
  endtask

  task automatic t_jump();
    prep();
    imem[0] = enc_j(3);
    imem[1] = enc_i(6'h2B, 0, 0, 4);
    imem[3] = enc_j(32'h40);
    start();
    step(1);
    chk("R8 jump target", imem_addr, 32'd12);
    step(1);
    chk("R8 jump far", imem_addr, 32'h100);
    step(1);
    chk("R8 jump from aliased slot", imem_addr, 32'd12);
  endtask

  task automatic t_zero();
    prep();
    dmem[0] = 32'd9; dmem[1] = 32'hAA;
    imem[0] = enc_i(6'h23, 0, 1, 0);
    imem[1] = enc_r(1, 1, 0, 6'h20);
    imem[2] = enc_i(6'h23, 0, 0, 0);
    imem[3] = enc_i(6'h2B, 0, 0, 4);
    imem[4] = enc_r(0, 1, 2, 6'h20);
    imem[5] = enc_i(6'h2B, 0, 2, 8);
    start();
    step(8);
    chk("R9 r0 reads zero", dmem[1], 32'd0);
    chk("R9 r0 as operand", dmem[2], 32'd9);
  endtask

  task automatic t_undef();
    prep();
    dmem[0] = 32'd3; dmem[4] = 32'h77;
    imem[0] = enc_i(6'h23, 0, 1, 0);
    imem[1] = enc_i(6'h3F, 0, 1, 16);
    imem[2] = enc_r(1, 1, 1, 6'h00);
    imem[3] = enc_r(1, 1, 1, 6'h21);
    imem[4] = enc_i(6'h2B, 0, 1, 4);
    start();
    step(1);
    chk("R10 undefined opcode no strobe", {31'd0, dmem_we}, 32'd0);
    step(1);
    chk("R11 pc after undefined opcode", imem_addr, 32'd8);
    step(1);
    chk("R11 pc after undefined funct", imem_addr, 32'd12);
    step(3);
    chk("R10 undefined writes no reg", dmem[1], 32'd3);
    chk("R10 undefined writes no mem", dmem[4], 32'h77);
  endtask

  initial begin
    t_alu();
    t_reset();
    t_mem();
    t_branch();
    t_jump();
    t_zero();
    t_undef();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule